// File: doc/BRIEF.md
# Frequency-Locked Loop Controller

This block keeps a digitally controlled oscillator running at a programmed multiple of a slow reference clock. The oscillator output is the block's own clock (`clk`). In that domain the block counts clock cycles from one rising edge of the reference to the next. It compares that count with a programmable target factor. After each reference period it moves a 12-bit control word by a single step toward the target. The control word feeds the oscillator. Its upper 7 bits choose one of 128 coarse taps, and its lower 5 bits set a modulation value that interpolates between neighbouring taps.

The reference clock is asynchronous to `clk`. It passes through a two-stage synchronizer and a rising-edge detector before it restarts the counter. A freeze input holds the control word during timing-critical intervals, such as the active part of a display line. Corrections then happen only in the gaps. A lock flag reports that several consecutive periods measured within one count of the target.

Top module: `fll_ctrl`

## Requirements
- R1: While `rst` is high and after its release, `ctrl_word` is 0x800 (tap 64, modulation 0), `meas_count` is 0 and `locked` is 0.
- R2: `meas_count` equals the number of `clk` cycles between two consecutive rising edges of `ref_clk`. It changes only when a new period completes.
- R3: When a completed count is below `target`, `ctrl_word` increases by exactly one. The modulation field `ctrl_word[4:0]` increments first, and a carry out of it increments the tap field `ctrl_word[11:5]`.
- R4: When a completed count is above `target`, `ctrl_word` decreases by exactly one.
- R5: When a completed count equals `target`, `ctrl_word` does not change.
- R6: `ctrl_word` changes by at most one step per reference rising edge, and only right after a completed measurement.
- R7: `ctrl_word` saturates at 0xFFF when stepping up and at 0x000 when stepping down, and never wraps.
- R8: While `freeze` is high, `ctrl_word` holds its value whatever the counts are. Stepping resumes after `freeze` returns low.
- R9: `locked` goes high on the 4th consecutive completed count within ±1 of `target`. It goes low on the first completed count outside that band.
- R10: With an oscillator whose period count rises with `ctrl_word`, the loop settles where the measured count equals `target`, and `locked` asserts.
- R11: The first reference rising edge after reset yields no measurement and no step, because no full period has been seen yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; every register of the block runs on it |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Slow reference clock, asynchronous to clk |
| target | input | 16 | Required clk cycles per reference period |
| freeze | input | 1 | High holds the control word |
| ctrl_word | output | 12 | Tap index [11:5] and modulation value [4:0] to the oscillator |
| meas_count | output | 16 | Last completed period count |
| locked | output | 1 | Count within ±1 of target for 4 periods in a row |

## Verification
The hardest conditions to reach are the two saturation limits. They lie more than two thousand single steps away from the reset word. The bench gets there by shortening the reference period to eight cycles and holding the target far above, then far below, the count, so both limits are reached in a few tens of thousands of cycles. The closed-loop check uses a bench oscillator model in which each period length is derived from the control word in force when that period starts. This reproduces the one-period lag between a correction and its effect on the measurement.

// File: rtl/fll_pkg.sv
package fll_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/fll_ref_sync.sv
module fll_ref_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic rise
);
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= ref_in;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rise <= 1'b0;
    else     rise <= chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  end
endmodule

// File: rtl/fll_period_counter.sv
module fll_period_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_pulse,
  output logic [CNT_W-1:0] meas,
  output logic             meas_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run_cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt    <= '0;
      meas       <= '0;
      meas_valid <= 1'b0;
      armed      <= 1'b0;
    end else begin
      meas_valid <= edge_pulse & armed;
      if (edge_pulse) begin
        armed   <= 1'b1;
        run_cnt <= CNT_W'(1);
        if (armed) meas <= run_cnt;
      end else if (run_cnt != CNT_MAX) begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fll_step_ctrl.sv
module fll_step_ctrl
  import fll_pkg::*;
#(
  parameter int          TAP_W      = 7,
  parameter int          MOD_W      = 5,
  parameter int          CNT_W      = 16,
  parameter int unsigned RESET_WORD = 12'h800
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   meas_valid,
  input  logic [CNT_W-1:0]       meas,
  input  logic [CNT_W-1:0]       target,
  input  logic                   freeze,
  output logic [TAP_W+MOD_W-1:0] word
);
  localparam int WORD_W = TAP_W + MOD_W;
  localparam logic [WORD_W-1:0] WORD_MAX = '1;
  localparam logic [WORD_W-1:0] WORD_MIN = '0;

  step_e dir;

  always_comb begin
    dir = STEP_HOLD;
    if (meas < target)      dir = STEP_UP;
    else if (meas > target) dir = STEP_DOWN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= WORD_W'(RESET_WORD);
    end else if (meas_valid && !freeze) begin
      case (dir)
        STEP_UP:   if (word != WORD_MAX) word <= word + 1'b1;
        STEP_DOWN: if (word != WORD_MIN) word <= word - 1'b1;
        default:   word <= word;
      endcase
    end
  end
endmodule

// File: rtl/fll_lock_det.sv
module fll_lock_det #(
  parameter int CNT_W        = 16,
  parameter int LOCK_PERIODS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meas_valid,
  input  logic [CNT_W-1:0] meas,
  input  logic [CNT_W-1:0] target,
  output logic             locked
);
  localparam int STREAK_W = $clog2(LOCK_PERIODS + 1);
  localparam logic [STREAK_W-1:0] STREAK_TOP = STREAK_W'(LOCK_PERIODS);

  logic [STREAK_W-1:0] streak;
  logic [CNT_W:0]      meas_x, target_x;
  logic                in_band;

  assign meas_x   = {1'b0, meas};
  assign target_x = {1'b0, target};
  assign in_band  = (meas_x + 1'b1 >= target_x) && (meas_x <= target_x + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      streak <= '0;
      locked <= 1'b0;
    end else if (meas_valid) begin
      if (in_band) begin
        if (streak != STREAK_TOP) streak <= streak + 1'b1;
        locked <= (streak + 1'b1 >= STREAK_TOP);
      end else begin
        streak <= '0;
        locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl #(
  parameter int          TAP_W        = 7,
  parameter int          MOD_W        = 5,
  parameter int          CNT_W        = 16,
  parameter int          SYNC_STAGES  = 2,
  parameter int          LOCK_PERIODS = 4,
  parameter int unsigned RESET_WORD   = 12'h800
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ref_clk,
  input  logic [CNT_W-1:0]       target,
  input  logic                   freeze,
  output logic [TAP_W+MOD_W-1:0] ctrl_word,
  output logic [CNT_W-1:0]       meas_count,
  output logic                   locked
);
  logic ref_rise;
  logic meas_valid;

  fll_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ref_in(ref_clk), .rise(ref_rise)
  );

  fll_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .edge_pulse(ref_rise),
    .meas(meas_count), .meas_valid(meas_valid)
  );

  fll_step_ctrl #(
    .TAP_W(TAP_W), .MOD_W(MOD_W), .CNT_W(CNT_W), .RESET_WORD(RESET_WORD)
  ) u_step (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas(meas_count),
    .target(target), .freeze(freeze), .word(ctrl_word)
  );

  fll_lock_det #(.CNT_W(CNT_W), .LOCK_PERIODS(LOCK_PERIODS)) u_lock (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas(meas_count),
    .target(target), .locked(locked)
  );
endmodule

// File: rtl/fll_ctrl_chk.sv
module fll_ctrl_chk #(
  parameter int TAP_W = 7,
  parameter int MOD_W = 5,
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   freeze,
  input logic [CNT_W-1:0]       target,
  input logic [TAP_W+MOD_W-1:0] ctrl_word,
  input logic [CNT_W-1:0]       meas_count,
  input logic                   meas_valid,
  input logic                   locked
);
  localparam int WORD_W = TAP_W + MOD_W;
  localparam logic [WORD_W-1:0] WORD_MAX = '1;

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word != $past(ctrl_word)) |->
      (ctrl_word == WORD_W'($past(ctrl_word) + 1'b1) ||
       ctrl_word == WORD_W'($past(ctrl_word) - 1'b1))); // R6

  AST_STEP_AFTER_MEAS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_word != $past(ctrl_word)) |-> $past(meas_valid)); // R6

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(ctrl_word)); // R8

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && !freeze && meas_count < target && ctrl_word != WORD_MAX) |=>
      (ctrl_word == WORD_W'($past(ctrl_word) + 1'b1))); // R3

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && !freeze && meas_count > target && ctrl_word != '0) |=>
      (ctrl_word == WORD_W'($past(ctrl_word) - 1'b1))); // R4

  AST_EQUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && meas_count == target) |=> $stable(ctrl_word)); // R5

  AST_MEAS_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (rst)
    !$stable(meas_count) |-> meas_valid); // R2

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && (({1'b0, meas_count} > {1'b0, target} + 1'b1) ||
                    ({1'b0, meas_count} + 1'b1 < {1'b0, target}))) |=> !locked); // R9
endmodule

bind fll_ctrl fll_ctrl_chk #(.TAP_W(TAP_W), .MOD_W(MOD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .freeze(freeze), .target(target),
  .ctrl_word(ctrl_word), .meas_count(meas_count),
  .meas_valid(meas_valid), .locked(locked)
);

// File: tb/tb_fll_ctrl.sv
module tb_fll_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_clk = 1'b0;
  logic [15:0] target = 16'd200;
  logic        freeze = 1'b0;
  logic [11:0] ctrl_word;
  logic [15:0] meas_count;
  logic        locked;

  int ref_per  = 0;
  bit osc_mode = 1'b0;
  int checks   = 0;
  int errors   = 0;
  int cycles   = 0;

  fll_ctrl dut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .target(target), .freeze(freeze),
    .ctrl_word(ctrl_word), .meas_count(meas_count), .locked(locked)
  );

  always #5 clk = ~clk;

  function automatic int osc_period(logic [11:0] w);
    return 40 + int'(w >> 5);
  endfunction

  initial begin
    forever begin
      if (ref_per == 0 && !osc_mode) begin
        @(negedge clk);
      end else begin
        int p;
        p = osc_mode ? osc_period(ctrl_word) : ref_per;
        ref_clk = 1'b1;
        repeat (p / 2) @(negedge clk);
        ref_clk = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge ref_clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    check(ctrl_word == 12'h800, "R1", "word in reset", ctrl_word, 12'h800);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(ctrl_word == 12'h800, "R1", "word after reset", ctrl_word, 12'h800);
    check(meas_count == 0, "R1", "count after reset", meas_count, 0);
    check(locked == 1'b0, "R1", "lock after reset", locked, 0);
  endtask

  task automatic t_first_edge;
    ref_per = 50;
    wait_edges(1);
    check(ctrl_word == 12'h800, "R11", "no step on first edge", ctrl_word, 12'h800);
    check(meas_count == 0, "R11", "no count on first edge", meas_count, 0);
    wait_edges(1);
    check(meas_count == 50, "R2", "period count", meas_count, 50);
    check(ctrl_word == 12'h801, "R3", "first up step", ctrl_word, 12'h801);
  endtask

  task automatic t_step_up;
    logic [11:0] w0;
    w0 = ctrl_word;
    wait_edges(40);
    check(ctrl_word == w0 + 12'd40, "R6", "one step per period up", ctrl_word, w0 + 40);
    check(ctrl_word[11:5] == w0[11:5] + 7'd1, "R3", "modulation carry into tap",
          ctrl_word[11:5], w0[11:5] + 1);
  endtask

  task automatic t_step_down;
    logic [11:0] w0;
    target = 16'd10;
    wait_edges(1);
    w0 = ctrl_word;
    wait_edges(40);
    check(ctrl_word == w0 - 12'd40, "R4", "one step per period down", ctrl_word, w0 - 40);
  endtask

  task automatic t_equal;
    logic [11:0] w0;
    target = 16'd50;
    wait_edges(1);
    w0 = ctrl_word;
    wait_edges(5);
    check(ctrl_word == w0, "R5", "hold when count equals target", ctrl_word, w0);
    check(meas_count == 50, "R2", "count steady", meas_count, 50);
  endtask

  task automatic t_lock;
    target = 16'd200;
    wait_edges(2);
    check(locked == 1'b0, "R9", "unlocked when far", locked, 0);
    target = 16'd51;
    wait_edges(3);
    check(locked == 1'b0, "R9", "not locked after 3 in band", locked, 0);
    wait_edges(1);
    check(locked == 1'b1, "R9", "locked after 4 in band", locked, 1);
    target = 16'd60;
    wait_edges(1);
    check(locked == 1'b0, "R9", "lock lost on far count", locked, 0);
  endtask

  task automatic t_freeze;
    logic [11:0] w0;
    target = 16'd200;
    wait_edges(1);
    freeze = 1'b1;
    w0 = ctrl_word;
    wait_edges(6);
    check(ctrl_word == w0, "R8", "held during freeze", ctrl_word, w0);
    freeze = 1'b0;
    wait_edges(3);
    check(ctrl_word == w0 + 12'd3, "R8", "resumes after freeze", ctrl_word, w0 + 3);
  endtask

  task automatic t_converge;
    target   = 16'd110;
    osc_mode = 1'b1;
    wait_edges(300);
    check(meas_count == 110, "R10", "settled count", meas_count, 110);
    check(ctrl_word[11:5] == 7'd70, "R10", "settled tap", ctrl_word[11:5], 70);
    check(locked == 1'b1, "R10", "locked in loop", locked, 1);
    osc_mode = 1'b0;
  endtask

  task automatic t_saturate;
    ref_per = 8;
    target  = 16'd1000;
    wait_edges(2000);
    check(ctrl_word == 12'hFFF, "R7", "top limit", ctrl_word, 12'hFFF);
    wait_edges(5);
    check(ctrl_word == 12'hFFF, "R7", "no wrap at top", ctrl_word, 12'hFFF);
    target = 16'd2;
    wait_edges(4200);
    check(ctrl_word == 12'h000, "R7", "bottom limit", ctrl_word, 0);
    wait_edges(5);
    check(ctrl_word == 12'h000, "R7", "no wrap at bottom", ctrl_word, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_first_edge();
    t_step_up();
    t_step_down();
    t_equal();
    t_lock();
    t_freeze();
    t_converge();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule